// File: doc/BRIEF.md
# Four-Leg Reference Level Splitter

Once per control sample this block turns three signed phase-to-neutral voltage references and the measured DC-bus voltage into switching targets for a four-leg, multi-level converter. It averages the largest and the smallest phase reference to form a common shift. The shift moves every phase leg toward the middle of the bus, and its negative becomes the reference of the fourth, neutral leg. The phase-to-neutral differences therefore stay as commanded.

Each of the four leg references is then scaled so that one unit equals one level step of the converter. It is lifted by half the level span so that it sits between zero and the top level, and it is clamped to that range. The block then splits the result into a whole level code and a fractional duty. The modulator downstream switches each leg between the coded level and the level above it, for the given fraction of the period.

A start strobe launches one computation. The block accepts a new start only when it is idle. After a fixed number of clock cycles a one-cycle valid strobe marks the result. The outputs keep their value until the next result.

Top module: `pwm_ref_decomposer`

## Requirements
- R1: While reset is asserted and after its release, `valid` is low and every level code and duty word reads zero until the first result.
- R2: A start sampled high on a clock edge while idle yields `valid` high for exactly one cycle, DUTY_FRAC+1 clock edges later. The level and duty outputs change only on that edge and hold their values until the next result.
- R3: The neutral leg reference (index 3) equals minus floor((max+min)/2) over the three phase references. Each phase leg reference is its input minus that same shift.
- R4: Each leg reference x is normalised to (LEVELS-1)*x/vdc + (LEVELS-1)/2, for vdc nonzero and unsigned.
- R5: Each leg's level code is the integer part of its normalised value. Its duty is floor(fraction * 2^DUTY_FRAC) in an unsigned DUTY_FRAC+1 bit word, where 2^DUTY_FRAC means 1.0.
- R6: A normalised value at or above LEVELS-1 gives level code LEVELS-2 with duty exactly 2^DUTY_FRAC.
- R7: A normalised value at or below zero gives level code 0 with duty 0.
- R8: A start raised while a computation is in progress is ignored. So is any change on the reference or bus inputs during a computation. Neither alters the result or its timing.
- R9: Output slots 0, 1 and 2 carry phases A, B and C, and slot 3 the neutral leg. Level codes count up from the lowest bus level: for three levels, codes 0, 1 and 2 stand for -vdc/2, 0 and +vdc/2.
- R10: With `valid` high, no duty word exceeds 2^DUTY_FRAC and no level code exceeds LEVELS-2.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Launch one computation |
| refA | input | REF_W | Phase A reference, signed |
| refB | input | REF_W | Phase B reference, signed |
| refC | input | REF_W | Phase C reference, signed |
| vdc | input | VDC_W | DC-bus voltage, unsigned, nonzero |
| valid | output | 1 | One-cycle result strobe |
| legLevel | output | 4 x clog2(LEVELS) | Level code per leg, slot 3 neutral |
| legDuty | output | 4 x (DUTY_FRAC+1) | Duty per leg, 2^DUTY_FRAC is full |

## Verification
A balanced all-zero reference checks that every leg lands exactly on the middle level with zero duty, which separates an off-by-half normalisation from a correct one. An asymmetric set with an odd negative max+min sum shows whether the shift rounds toward minus infinity and whether the neutral leg takes the negated shift. Wide references on a small bus drive the top and bottom clamps, including the exact full-duty case. Random references and bus voltages, compared with a bench model, cover the division across its whole range. One run raises a second start and changes the inputs mid-computation, which separates a block that ignores them from one that reloads.

// File: rtl/legsplit_pkg.sv
package legsplit_pkg;
  localparam int NUM_LEGS    = 4;
  localparam int LEG_NEUTRAL = 3;

  typedef struct packed {
    logic load;    // capture inputs, compute levels and remainders
    logic step;    // one restoring-division iteration on every leg
    logic finish;  // last iteration, publish results
  } seq_ctrl_t;
endpackage

// File: rtl/legsplit_seq.sv
module legsplit_seq
  import legsplit_pkg::*;
#(
  parameter int ITERS = 13
) (
  input  logic      clk,
  input  logic      rstN,
  input  logic      start,
  output seq_ctrl_t ctrl
);
  localparam int CNT_W = $clog2(ITERS + 1);

  logic [CNT_W-1:0] cnt;

  always_comb begin
    ctrl.load   = start && (cnt == '0);
    ctrl.step   = (cnt != '0);
    ctrl.finish = (cnt == CNT_W'(1));
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)           cnt <= '0;
    else if (ctrl.load)  cnt <= CNT_W'(ITERS);
    else if (ctrl.step)  cnt <= cnt - CNT_W'(1);
  end

  // R8: a start that arrives while busy must not restart the count
  p_busy_no_reload_r8: assert property (@(posedge clk) disable iff (!rstN)
    (start && ctrl.step && !ctrl.finish) |=> !ctrl.load);
endmodule

// File: rtl/legsplit_datapath.sv
module legsplit_datapath
  import legsplit_pkg::*;
#(
  parameter int REF_W     = 16,
  parameter int VDC_W     = 16,
  parameter int LEVELS    = 3,
  parameter int DUTY_FRAC = 12
) (
  input  logic                                       clk,
  input  logic                                       rstN,
  input  seq_ctrl_t                                  ctrl,
  input  logic signed [REF_W-1:0]                    refA,
  input  logic signed [REF_W-1:0]                    refB,
  input  logic signed [REF_W-1:0]                    refC,
  input  logic [VDC_W-1:0]                           vdc,
  output logic                                       valid,
  output logic [NUM_LEGS-1:0][$clog2(LEVELS)-1:0]    legLevel,
  output logic [NUM_LEGS-1:0][DUTY_FRAC:0]           legDuty
);
  localparam int LVL_W = $clog2(LEVELS);
  localparam int LEG_W = REF_W + 2;
  localparam int DEN_W = VDC_W + 1;
  localparam int REM_W = DEN_W + 1;
  localparam int ACC_W = ((REF_W > VDC_W) ? REF_W : VDC_W) + $clog2(LEVELS) + 5;
  localparam logic signed [ACC_W-1:0] STEP_S = ACC_W'(LEVELS - 1);
  localparam logic [DUTY_FRAC:0] DUTY_ONE = (DUTY_FRAC+1)'(1) << DUTY_FRAC;

  // Common shift: floor((max + min) / 2) over the phase references
  logic signed [REF_W-1:0] refMax, refMin;
  logic signed [REF_W:0]   sumS, shiftS;
  logic [DEN_W-1:0]        denU;
  logic signed [ACC_W-1:0] vdcS, denS, fullS;

  always_comb begin
    refMax = refA;
    refMin = refA;
    if (refB > refMax) refMax = refB;
    if (refC > refMax) refMax = refC;
    if (refB < refMin) refMin = refB;
    if (refC < refMin) refMin = refC;
    sumS   = (REF_W+1)'(refMax) + (REF_W+1)'(refMin);
    shiftS = sumS >>> 1;
    denU   = {vdc, 1'b0};
    vdcS   = ACC_W'($signed({1'b0, vdc}));
    denS   = ACC_W'($signed({1'b0, denU}));
    fullS  = denS * STEP_S;
  end

  logic [DEN_W-1:0] denReg;
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)          denReg <= '0;
    else if (ctrl.load) denReg <= denU;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) valid <= 1'b0;
    else       valid <= ctrl.finish;
  end

  for (genvar g = 0; g < NUM_LEGS; g++) begin : gLeg
    logic signed [LEG_W-1:0] legRef;
    logic signed [ACC_W-1:0] numer, clamped, base, remS;
    logic [LVL_W-1:0]        offCalc, offReg;
    logic [REM_W-1:0]        remReg, nextRem;
    logic [REM_W-2:0]        subRem;
    logic [DUTY_FRAC-1:0]    qReg;
    logic                    bitNow;

    if (g == LEG_NEUTRAL) begin : gNeutral
      always_comb legRef = -LEG_W'(shiftS);
    end else if (g == 0) begin : gPhA
      always_comb legRef = LEG_W'(refA) - LEG_W'(shiftS);
    end else if (g == 1) begin : gPhB
      always_comb legRef = LEG_W'(refB) - LEG_W'(shiftS);
    end else begin : gPhC
      always_comb legRef = LEG_W'(refC) - LEG_W'(shiftS);
    end

    // Scale to level steps, lift by half the span, clamp, split
    always_comb begin
      numer = ((ACC_W'(legRef) <<< 1) + vdcS) * STEP_S;
      if (numer[ACC_W-1])    clamped = '0;
      else if (numer > fullS) clamped = fullS;
      else                   clamped = numer;
      offCalc = '0;
      base    = '0;
      for (int k = 1; k <= LEVELS - 2; k++) begin
        if (clamped >= denS * ACC_W'(k)) begin
          offCalc = LVL_W'(k);
          base    = denS * ACC_W'(k);
        end
      end
      remS = clamped - base;
    end

    // One restoring-division step of remainder / (2*vdc)
    always_comb begin
      bitNow  = (remReg >= {1'b0, denReg});
      subRem  = (REM_W-1)'(bitNow ? (remReg - {1'b0, denReg}) : remReg);
      nextRem = {subRem, 1'b0};
    end

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        offReg <= '0;
        remReg <= '0;
        qReg   <= '0;
      end else if (ctrl.load) begin
        offReg <= offCalc;
        remReg <= REM_W'(remS);
        qReg   <= '0;
      end else if (ctrl.step) begin
        remReg <= nextRem;
        qReg   <= {qReg[DUTY_FRAC-2:0], bitNow};
      end
    end

    logic [LVL_W-1:0]   lvlOut;
    logic [DUTY_FRAC:0] dutyOut;
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        lvlOut  <= '0;
        dutyOut <= '0;
      end else if (ctrl.finish) begin
        lvlOut  <= offReg;
        dutyOut <= {qReg, bitNow};
      end
    end
    assign legLevel[g] = lvlOut;
    assign legDuty[g]  = dutyOut;

    p_duty_cap_r10: assert property (@(posedge clk) disable iff (!rstN)
      valid |-> (dutyOut <= DUTY_ONE));
    p_level_cap_r10: assert property (@(posedge clk) disable iff (!rstN)
      valid |-> (lvlOut <= LVL_W'(LEVELS - 2)));
    p_full_duty_top_r6: assert property (@(posedge clk) disable iff (!rstN)
      (valid && dutyOut == DUTY_ONE) |-> (lvlOut == LVL_W'(LEVELS - 2)));
  end

  p_single_valid_r2: assert property (@(posedge clk) disable iff (!rstN)
    valid |=> !valid);
  p_hold_between_r2: assert property (@(posedge clk) disable iff (!rstN)
    !valid |-> ($stable(legDuty) && $stable(legLevel)));
endmodule

// File: rtl/pwm_ref_decomposer.sv
module pwm_ref_decomposer
  import legsplit_pkg::*;
#(
  parameter int REF_W     = 16,
  parameter int VDC_W     = 16,
  parameter int LEVELS    = 3,
  parameter int DUTY_FRAC = 12
) (
  input  logic                                    clk,
  input  logic                                    rstN,
  input  logic                                    start,
  input  logic signed [REF_W-1:0]                 refA,
  input  logic signed [REF_W-1:0]                 refB,
  input  logic signed [REF_W-1:0]                 refC,
  input  logic [VDC_W-1:0]                        vdc,
  output logic                                    valid,
  output logic [3:0][$clog2(LEVELS)-1:0]          legLevel,
  output logic [3:0][DUTY_FRAC:0]                 legDuty
);
  localparam int ITERS = DUTY_FRAC + 1;

  seq_ctrl_t ctrl;

  legsplit_seq #(.ITERS(ITERS)) uSeq (
    .clk   (clk),
    .rstN  (rstN),
    .start (start),
    .ctrl  (ctrl)
  );

  legsplit_datapath #(
    .REF_W(REF_W), .VDC_W(VDC_W), .LEVELS(LEVELS), .DUTY_FRAC(DUTY_FRAC)
  ) uPath (
    .clk      (clk),
    .rstN     (rstN),
    .ctrl     (ctrl),
    .refA     (refA),
    .refB     (refB),
    .refC     (refC),
    .vdc      (vdc),
    .valid    (valid),
    .legLevel (legLevel),
    .legDuty  (legDuty)
  );
endmodule

// File: tb/pwm_ref_decomposer_test.sv
module pwm_ref_decomposer_test;
  localparam int L   = 3;
  localparam int F   = 12;
  localparam int IT  = F + 1;
  localparam int ONE = 1 << F;

  logic clk = 1'b0, rstN = 1'b0, start = 1'b0;
  logic signed [15:0] refA = '0, refB = '0, refC = '0;
  logic [15:0] vdc = '0;
  logic valid;
  logic [3:0][1:0] legLevel;
  logic [3:0][F:0] legDuty;

  pwm_ref_decomposer uut (
    .clk(clk), .rstN(rstN), .start(start), .refA(refA), .refB(refB),
    .refC(refC), .vdc(vdc), .valid(valid), .legLevel(legLevel), .legDuty(legDuty)
  );

  always #10 clk = ~clk;

  int checks = 0, failures = 0;
  int expLv[4], expDu[4];
  bit done = 1'b0;

  task automatic chk(string tag, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  task automatic model(int a, int b, int c, int v);
    int r[3];
    int mx, mn, s;
    longint leg, n, d, full, off, rem;
    r[0] = a; r[1] = b; r[2] = c;
    mx = a; mn = a;
    for (int i = 1; i < 3; i++) begin
      if (r[i] > mx) mx = r[i];
      if (r[i] < mn) mn = r[i];
    end
    s = (mx + mn) >>> 1;
    for (int i = 0; i < 4; i++) begin
      leg  = (i == 3) ? -longint'(s) : longint'(r[i] - s);
      n    = (L - 1) * (2 * leg + v);
      d    = 2 * longint'(v);
      full = (L - 1) * d;
      if (n < 0) n = 0;
      if (n > full) n = full;
      off = n / d;
      if (off > L - 2) off = L - 2;
      rem = n - off * d;
      expLv[i] = int'(off);
      expDu[i] = int'((rem * ONE) / d);
    end
  endtask

  task automatic runVec(int a, int b, int c, int v, bit busy, string legTag);
    int n;
    model(a, b, c, v);
    @(negedge clk);
    refA = 16'(a); refB = 16'(b); refC = 16'(c); vdc = 16'(v); start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    n = 0;
    while (!valid && n < IT + 8) begin
      @(negedge clk);
      n++;
      if (busy && n == 3) begin
        start = 1'b1;
        refA = refA ^ 16'h5a5a; refB = refB ^ 16'h0ff0; vdc = vdc ^ 16'h0f00;
      end
      if (busy && n == 4) start = 1'b0;
    end
    chk(busy ? "R8" : "R2", "latency", n, IT);
    for (int i = 0; i < 4; i++) begin
      chk(busy ? "R8" : ((i == 3) ? "R3" : legTag), $sformatf("level leg%0d", i),
          int'(legLevel[i]), expLv[i]);
      chk(busy ? "R8" : ((i == 3) ? "R3" : legTag), $sformatf("duty leg%0d", i),
          int'(legDuty[i]), expDu[i]);
    end
    @(negedge clk);
    chk("R2", "valid one cycle", int'(valid), 0);
    chk("R2", "duty held", int'(legDuty[0]), expDu[0]);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL R2 watchdog actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    int a, b, c, v;
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    // R1: reset state
    chk("R1", "valid in reset", int'(valid), 0);
    for (int i = 0; i < 4; i++) begin
      chk("R1", "level in reset", int'(legLevel[i]), 0);
      chk("R1", "duty in reset", int'(legDuty[i]), 0);
    end
    rstN = 1'b1;
    repeat (2) @(negedge clk);
    chk("R1", "valid after reset", int'(valid), 0);

    // R4: balanced zero sits exactly on the middle level
    runVec(0, 0, 0, 1000, 1'b0, "R4");
    for (int i = 0; i < 4; i++) begin
      chk("R4", "zero ref level", int'(legLevel[i]), 1);
      chk("R4", "zero ref duty", int'(legDuty[i]), 0);
    end

    // R9 / R3: slot order and neutral leg value worked by hand
    runVec(400, -100, -300, 1000, 1'b0, "R9");
    chk("R9", "phase A level", int'(legLevel[0]), 1);
    chk("R9", "phase A duty", int'(legDuty[0]), 2867);
    chk("R3", "neutral level", int'(legLevel[3]), 0);
    chk("R3", "neutral duty", int'(legDuty[3]), 3686);

    // R6 / R7: clamps at both ends
    runVec(20000, 0, -20000, 1000, 1'b0, "R5");
    chk("R6", "top clamp level", int'(legLevel[0]), 1);
    chk("R6", "top clamp duty", int'(legDuty[0]), ONE);
    chk("R7", "bottom clamp level", int'(legLevel[2]), 0);
    chk("R7", "bottom clamp duty", int'(legDuty[2]), 0);

    // R3: odd negative sum rounds toward minus infinity
    runVec(-3, -4, -4, 7, 1'b0, "R5");
    // R5: extremes of input range
    runVec(32767, -32768, 0, 65535, 1'b0, "R5");
    runVec(1, 0, -1, 1, 1'b0, "R5");

    // R8: start and input changes while busy are ignored
    runVec(1234, -2222, 500, 5000, 1'b1, "R8");

    // R5 / R10: random references and bus voltages
    for (int k = 0; k < 300; k++) begin
      if (k % 3 == 0) begin
        a = int'($urandom % 4001) - 2000;
        b = int'($urandom % 4001) - 2000;
        c = int'($urandom % 4001) - 2000;
        v = 1 + int'($urandom % 3000);
      end else begin
        a = int'(16'($urandom)) - 32768;
        b = int'(16'($urandom)) - 32768;
        c = int'(16'($urandom)) - 32768;
        v = 1 + int'($urandom % 65535);
      end
      runVec(a, b, c, v, 1'b0, "R5");
    end

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule